// File: doc/BRIEF.md
# Thresholded Sobel Edge Mask

This block turns a raster stream of 8-bit grayscale pixels into a binary edge mask. It takes one pixel per clock when the valid input is high. It holds the two previous image rows in on-chip line stores and keeps a sliding 3x3 neighbourhood in registers. For every neighbourhood that lies fully inside the image, it computes the horizontal and vertical Sobel gradients. Their absolute values are added into a magnitude, and that magnitude is compared against a threshold input.

The convolution uses stride 1 and no padding. A square image of side N therefore produces a square result of side N-2, which is 198x198 for the default 200x200 input. Each result leaves the block as an 8-bit colour word in a 3-3-2 red/green/blue layout. The word comes with a write strobe and a linear write address, so it can go straight into the write port of a frame memory. Strong edges become white and everything else becomes black.

The block runs entirely in the pixel-producer clock domain. A frame-start input realigns the raster position and the write address to the first pixel of a new image.

Top module: `sobel_edge_mask`

## Requirements
- R1: For an input frame of IMG_W x IMG_H pixels (default 200x200), the block issues exactly (IMG_W-2)*(IMG_H-2) write strobes (39204 by default). No strobe is issued for an input pixel that lies in row 0, row 1, column 0 or column 1 of its frame.
- R2: The strobe produced by input pixel (row r, column c), counted from 0 in arrival order, carries address (r-2)*(IMG_W-2) + (c-2), so results leave in row-major order.
- R3: The window p[i][j] has i=0 as the oldest of the three rows and j=0 as the leftmost of the three columns, and its bottom-right pixel is the newest input. Over this window, Gx = (p02 + 2*p12 + p22) - (p00 + 2*p10 + p20) and Gy = (p20 + 2*p21 + p22) - (p00 + 2*p01 + p02), both evaluated without overflow.
- R4: The magnitude is |Gx| + |Gy|. out_data is 8'hFF (all colour bits set, white) when the magnitude is strictly greater than `threshold`. Otherwise it is 8'h00 (black), and that includes the case where the magnitude equals the threshold.
- R5: A pixel is accepted on a rising edge where pix_valid is high. The resulting strobe is visible after the next rising edge, a fixed two-edge latency. Cycles with pix_valid low advance neither the raster position nor the window.
- R6: After address (IMG_W-2)*(IMG_H-2)-1 (39203 by default), the next strobe carries address 0, even when the following frame starts without frame_start.
- R7: A pixel presented with frame_start high is taken as row 0, column 0 of a new frame, and the first strobe of that frame carries address 0. This holds even if the previous frame was cut short.
- R8: While rst_n is low, and after it is released until the first accepted pixel, out_we, out_addr and out_data are all 0.
- R9: The magnitude never exceeds 8*255 = 2040, so it always fits in the 11-bit threshold range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Marks the pixel on the bus as the first pixel of a frame |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_data | input | 8 | Grayscale input pixel |
| threshold | input | 11 | Magnitude threshold; a result is foreground only if the magnitude is above it |
| out_we | output | 1 | Write strobe for one result pixel |
| out_addr | output | 16 | Linear write address of the result pixel |
| out_data | output | 8 | Result colour word: 8'hFF for an edge, 8'h00 otherwise |

## Verification
The assertions assume that pixels arrive in row-major order with exactly IMG_W accepted pixels per row. They also assume that frame_start is raised only together with the first pixel of a frame, and that the threshold does not change while a result is in flight. The stimulus follows these rules. It drives whole rows, with idle cycles inserted only between accepted pixels. It raises frame_start only on a frame's first pixel, and it changes the threshold only after the pipeline has drained. The one deliberately truncated frame ends on an accepted pixel, and the next frame is then started with frame_start.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

  localparam int PIX_W   = 8;
  localparam int GRAD_W  = PIX_W + 3;
  localparam int MAG_W   = PIX_W + 3;
  localparam int TAPS    = 9;
  localparam int MAG_MAX = 8 * ((1 << PIX_W) - 1);

  localparam logic [PIX_W-1:0] FG_CODE = '1;
  localparam logic [PIX_W-1:0] BG_CODE = '0;

  // Window word: element (row*3 + col), row 0 = oldest line, col 0 = leftmost.
  typedef logic [TAPS-1:0][PIX_W-1:0] win_t;

  function automatic logic signed [GRAD_W-1:0] tap(input win_t w, input int idx);
    return $signed({{(GRAD_W-PIX_W){1'b0}}, w[idx]});
  endfunction

  function automatic logic signed [GRAD_W-1:0] grad_x(input win_t w);
    logic signed [GRAD_W-1:0] right, left;
    right = tap(w, 2) + (tap(w, 5) <<< 1) + tap(w, 8);
    left  = tap(w, 0) + (tap(w, 3) <<< 1) + tap(w, 6);
    return right - left;
  endfunction

  function automatic logic signed [GRAD_W-1:0] grad_y(input win_t w);
    logic signed [GRAD_W-1:0] lower, upper;
    lower = tap(w, 6) + (tap(w, 7) <<< 1) + tap(w, 8);
    upper = tap(w, 0) + (tap(w, 1) <<< 1) + tap(w, 2);
    return lower - upper;
  endfunction

  function automatic logic [MAG_W-1:0] abs_val(input logic signed [GRAD_W-1:0] g);
    logic signed [GRAD_W-1:0] neg;
    neg = -g;
    return g[GRAD_W-1] ? MAG_W'(neg) : MAG_W'(g);
  endfunction

  function automatic logic [MAG_W-1:0] grad_mag(input win_t w);
    return abs_val(grad_x(w)) + abs_val(grad_y(w));
  endfunction

endpackage

// File: rtl/raster_track.sv
module raster_track #(
  parameter  int IMG_W = 200,
  parameter  int IMG_H = 200,
  localparam int COL_W = $clog2(IMG_W),
  localparam int ROW_W = $clog2(IMG_H)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             pix_valid,
  output logic [COL_W-1:0] pos_col,
  output logic             win_ok
);

  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] pos_row;
  logic             last_col;
  logic             last_row;
  logic             inner_pos;

  assign pos_col   = frame_start ? '0 : col_q;
  assign pos_row   = frame_start ? '0 : row_q;
  assign last_col  = (pos_col == COL_W'(IMG_W - 1));
  assign last_row  = (pos_row == ROW_W'(IMG_H - 1));
  assign inner_pos = (pos_row >= ROW_W'(2)) && (pos_col >= COL_W'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      row_q  <= '0;
      win_ok <= 1'b0;
    end else begin
      win_ok <= pix_valid && inner_pos;
      if (pix_valid) begin
        if (last_col) begin
          col_q <= '0;
          row_q <= last_row ? '0 : pos_row + 1'b1;
        end else begin
          col_q <= pos_col + 1'b1;
          row_q <= pos_row;
        end
      end else if (frame_start) begin
        col_q <= '0;
        row_q <= '0;
      end
    end
  end

  // R1
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_q < COL_W'(IMG_W)) && (row_q < ROW_W'(IMG_H)));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_valid && !frame_start) |=> ($stable(col_q) && $stable(row_q)));

endmodule

// File: rtl/line_window.sv
module line_window
  import sobel_pkg::*;
#(
  parameter  int IMG_W = 200,
  localparam int COL_W = $clog2(IMG_W),
  localparam int ROWS  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [COL_W-1:0] pos_col,
  input  logic [PIX_W-1:0] pix,
  output win_t             win
);

  logic [PIX_W-1:0] line_near [IMG_W];
  logic [PIX_W-1:0] line_far  [IMG_W];
  logic [ROWS-1:0][PIX_W-1:0] fresh;

  // Column entering the window: index 0 oldest row, index 2 newest pixel.
  assign fresh[0] = line_far[pos_col];
  assign fresh[1] = line_near[pos_col];
  assign fresh[2] = pix;

  always_ff @(posedge clk) begin
    if (accept) begin
      line_far[pos_col]  <= line_near[pos_col];
      line_near[pos_col] <= pix;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win[r*3+0] <= '0;
        win[r*3+1] <= '0;
        win[r*3+2] <= '0;
      end else if (accept) begin
        win[r*3+0] <= win[r*3+1];
        win[r*3+1] <= win[r*3+2];
        win[r*3+2] <= fresh[r];
      end
    end
  end

  // R3
  newest_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (win[8] == $past(pix)));

endmodule

// File: rtl/grad_thresh.sv
module grad_thresh
  import sobel_pkg::*;
#(
  parameter  int OUT_PIX = 39204,
  localparam int ADDR_W  = $clog2(OUT_PIX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              win_ok,
  input  win_t              win,
  input  logic [MAG_W-1:0]  threshold,
  output logic              out_we,
  output logic [ADDR_W-1:0] out_addr,
  output logic [PIX_W-1:0]  out_data
);

  logic [MAG_W-1:0]  mag;
  logic              above;
  logic [ADDR_W-1:0] next_addr;
  logic              addr_last;

  assign mag       = grad_mag(win);
  assign above     = mag > threshold;
  assign addr_last = (next_addr == ADDR_W'(OUT_PIX - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_we    <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
      next_addr <= '0;
    end else begin
      out_we <= win_ok;
      if (win_ok) begin
        out_addr <= next_addr;
        out_data <= above ? FG_CODE : BG_CODE;
      end
      if (frame_start) begin
        next_addr <= '0;
      end else if (win_ok) begin
        next_addr <= addr_last ? '0 : next_addr + 1'b1;
      end
    end
  end

  // R9
  mag_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_ok |-> (mag <= MAG_W'(MAG_MAX)));

  // R4
  data_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> ((out_data == FG_CODE) || (out_data == BG_CODE)));

  // R1
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> (out_addr < ADDR_W'(OUT_PIX)));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_we && $past(out_we)) |->
      (out_addr == (($past(out_addr) == ADDR_W'(OUT_PIX - 1)) ? '0 : $past(out_addr) + 1'b1)));

endmodule

// File: rtl/sobel_edge_mask.sv
module sobel_edge_mask
  import sobel_pkg::*;
#(
  parameter  int IMG_W   = 200,
  parameter  int IMG_H   = 200,
  localparam int OUT_PIX = (IMG_W - 2) * (IMG_H - 2),
  localparam int ADDR_W  = $clog2(OUT_PIX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic [MAG_W-1:0]  threshold,
  output logic              out_we,
  output logic [ADDR_W-1:0] out_addr,
  output logic [PIX_W-1:0]  out_data
);

  localparam int COL_W = $clog2(IMG_W);

  logic [COL_W-1:0] pos_col;
  logic             win_ok;
  win_t             win;

  raster_track #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .pix_valid   (pix_valid),
    .pos_col     (pos_col),
    .win_ok      (win_ok)
  );

  line_window #(.IMG_W(IMG_W)) u_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (pix_valid),
    .pos_col (pos_col),
    .pix     (pix_data),
    .win     (win)
  );

  grad_thresh #(.OUT_PIX(OUT_PIX)) u_grad (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .win_ok      (win_ok),
    .win         (win),
    .threshold   (threshold),
    .out_we      (out_we),
    .out_addr    (out_addr),
    .out_data    (out_data)
  );

  // R5
  strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> $past(pix_valid, 2));

endmodule

// File: tb/test_sobel_edge_mask.sv
`timescale 1ns/100ps
module test_sobel_edge_mask;

  localparam int W = 200;
  localparam int H = 200;
  localparam int NOUT = (W - 2) * (H - 2);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_data = '0;
  logic [10:0] threshold = '0;
  logic        out_we;
  logic [15:0] out_addr;
  logic [7:0]  out_data;

  sobel_edge_mask i_sobel_edge_mask (
    .clk (clk), .rst_n (rst_n), .frame_start (frame_start),
    .pix_valid (pix_valid), .pix_data (pix_data), .threshold (threshold),
    .out_we (out_we), .out_addr (out_addr), .out_data (out_data)
  );

  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit mon_on = 0;
  bit done = 0;
  int img [H][W];
  int q_due[$];
  int q_addr[$];
  int q_data[$];
  int m_row = 0, m_col = 0, m_addr = 0;
  int thr = 0;
  int seg_strobes = 0;
  int seg_first = -1;
  int unsigned seed = 32'h1234_5678;

  function automatic int next_rand();
    seed = seed * 1103515245 + 12345;
    return int'((seed >> 16) & 255);
  endfunction

  function automatic int ref_pixel(int r, int c, int t);
    int sx = 0, sy = 0, mag;
    for (int dr = 0; dr < 3; dr++) begin
      for (int dc = 0; dc < 3; dc++) begin
        int v = img[r-2+dr][c-2+dc];
        sx += (dc - 1) * ((dr == 1) ? 2 : 1) * v;
        sy += (dr - 1) * ((dc == 1) ? 2 : 1) * v;
      end
    end
    mag = (sx < 0 ? -sx : sx) + (sy < 0 ? -sy : sy);
    return (mag > t) ? 255 : 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push_pix(input int v, input bit fs);
    @(posedge clk); #1;
    frame_start = fs;
    pix_valid = 1'b1;
    pix_data = 8'(v);
    if (fs) begin m_row = 0; m_col = 0; m_addr = 0; end
    img[m_row][m_col] = v;
    if (m_row >= 2 && m_col >= 2) begin
      q_due.push_back(cyc + 3);
      q_addr.push_back(m_addr);
      q_data.push_back(ref_pixel(m_row, m_col, thr));
      m_addr = (m_addr == NOUT - 1) ? 0 : m_addr + 1;
    end
    if (m_col == W - 1) begin
      m_col = 0;
      m_row = (m_row == H - 1) ? 0 : m_row + 1;
    end else begin
      m_col++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      frame_start = 1'b0;
      pix_valid = 1'b0;
      pix_data = 8'(next_rand());
    end
  endtask

  task automatic set_thr(input int t);
    thr = t;
    threshold = 11'(t);
  endtask

  task automatic start_seg();
    seg_strobes = 0;
    seg_first = -1;
  endtask

  // Reference comparison on every falling edge.
  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (out_we) begin
        seg_strobes++;
        if (seg_first < 0) seg_first = int'(out_addr);
        if (q_due.size() == 0) begin
          check(1'b0, "R5 strobe with no pending result", 1, 0);
        end else begin
          check(q_due[0] == cyc, "R5 strobe cycle", cyc, q_due[0]);
          check(int'(out_addr) == q_addr[0], "R2 R6 R7 address", int'(out_addr), q_addr[0]);
          check(int'(out_data) == q_data[0], "R3 R4 pixel code", int'(out_data), q_data[0]);
          void'(q_due.pop_front()); void'(q_addr.pop_front()); void'(q_data.pop_front());
        end
      end else if (q_due.size() > 0 && q_due[0] <= cyc) begin
        check(1'b0, "R1 missing strobe", 0, 1);
        void'(q_due.pop_front()); void'(q_addr.pop_front()); void'(q_data.pop_front());
      end
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R5 watchdog expired actual=%0d expected=finish", cyc);
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    set_thr(300);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 outputs held clear during reset
    check(out_we == 1'b0 && out_addr == 16'd0 && out_data == 8'd0, "R8 in reset", int'(out_we), 0);
    #1 rst_n = 1'b1;
    idle(3);
    @(negedge clk);
    check(out_we == 1'b0, "R8 strobe after reset", int'(out_we), 0);
    check(out_addr == 16'd0, "R8 address after reset", int'(out_addr), 0);
    check(out_data == 8'd0, "R8 data after reset", int'(out_data), 0);
    mon_on = 1;

    // Frame 1: pseudo-random, no gaps, frame_start on first pixel.
    start_seg();
    for (int i = 0; i < W * H; i++) push_pix(next_rand(), i == 0);
    idle(5);
    check(seg_strobes == NOUT, "R1 strobes in frame 1", seg_strobes, NOUT);
    check(seg_first == 0, "R7 first address frame 1", seg_first, 0);

    // Truncated frame: two rows plus 60 pixels.
    start_seg();
    for (int i = 0; i < 2 * W + 60; i++) push_pix(next_rand(), 1'b0);
    idle(5);
    check(seg_strobes == 58, "R1 strobes in truncated frame", seg_strobes, 58);
    check(seg_first == 0, "R6 wrap after full frame", seg_first, 0);

    // Frame 2: restart with frame_start, gaps in valid, threshold zero.
    set_thr(0);
    start_seg();
    begin
      int sent = 0;
      int step = 0;
      while (sent < W * H) begin
        if (step % 5 == 3) idle(1);
        else begin
          push_pix(next_rand(), sent == 0);
          sent++;
        end
        step++;
      end
    end
    idle(5);
    check(seg_strobes == NOUT, "R1 R5 strobes in gapped frame 2", seg_strobes, NOUT);
    check(seg_first == 0, "R7 restart address frame 2", seg_first, 0);

    // Frame 3: vertical edges, equality at the threshold, no frame_start.
    set_thr(1016);
    start_seg();
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++)
        push_pix((c < 100) ? ((r < 100) ? 0 : 1) : 255, 1'b0);
    idle(5);
    check(seg_strobes == NOUT, "R1 strobes in frame 3", seg_strobes, NOUT);
    check(seg_first == 0, "R6 wrap into frame 3", seg_first, 0);
    check(q_due.size() == 0, "R1 no outstanding results", q_due.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end

endmodule